// File: doc/BRIEF.md
# Dual-Mode Protection Guard CRC Engine

This block computes the guard field of a block protection tuple from a byte stream. It takes one byte per clock and folds it into a running CRC. The CRC can be either of two kinds, chosen when a computation starts:

- **Short mode** gives a 16-bit CRC. The register is seeded with zero and shifts left, most significant bit first. The polynomial is 0x8BB7 and there is no final inversion.
- **Long mode** gives a 64-bit CRC. The register is seeded with all ones and shifts right, least significant bit first. It uses the reflected form 0x9A6C9329AC4BC9B5 of the polynomial 0xAD93D23594C93659, and the result is inverted at the end.

A caller pulses start to reload the seed, then streams the bytes of a sector. It flags the final byte of the sector, and one clock later the finished guard is presented with a done strobe. The guard may be spread over a data segment followed by a metadata segment. To do this, the caller streams the metadata bytes after the data bytes without a new start pulse. The running value is held unchanged through any idle cycles between the two segments, and a second last flag delivers the guard over both. Assembling the tuple, buffering and command parsing are left to neighbouring logic.

Top module: `guard_crc_engine`

## Requirements
- R1: After reset, done_o is 0 and guard_o is all zeros.
- R2: In short mode (mode_i = 0 at start), the guard is computed as follows:
  - The register is seeded with zero.
  - Each byte is XORed into bits 15:8, and the register then shifts left eight times with polynomial 0x8BB7.
  - No inversion is applied.
  - The result is in guard_o[15:0], with guard_o[63:16] zero.
  - The nine ASCII bytes "123456789" give 0xD0DB.
- R3: In long mode (mode_i = 1 at start), the guard is computed as follows:
  - The register is seeded with all ones.
  - Each byte is XORed into bits 7:0, and the register then shifts right eight times with polynomial 0x9A6C9329AC4BC9B5.
  - guard_o is the register inverted.
  - "123456789" gives 0xAE8B14860A799888.
- R4: One byte is consumed on every clock with valid_i high. A clock with both valid_i and start_i low leaves the running value, and therefore guard_o, unchanged.
- R5: done_o is high in the cycle after a clock that takes a byte with last_i high, and is low otherwise.
- R6: start_i reloads the seed of the mode on mode_i. A start with valid_i low leaves guard_o at zero in either mode. A start with valid_i high folds that byte in on top of the seed.
- R7: mode_i is sampled only on a start cycle. Changing it at any other time has no effect on the result.
- R8: Bytes that follow a done strobe without a start continue the CRC from the value before finishing. A data segment and a metadata segment sent this way give the guard of their concatenation.
- R9: An all-zero 512-byte block gives a guard of zero in short mode, and a nonzero guard equal to the reference value in long mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | CRC select at start: 0 short 16-bit, 1 long 64-bit |
| start_i | input | 1 | Reload the seed of the selected mode |
| valid_i | input | 1 | data_i carries a byte this cycle |
| data_i | input | 8 | Stream byte |
| last_i | input | 1 | Byte is the final one of the guard span |
| done_o | output | 1 | Guard is valid this cycle |
| guard_o | output | 64 | Finished guard (short mode in bits 15:0) |

## Verification
If a state bit goes wrong, the bad value stays in the running register. It shows up at the port as a guard mismatch at the next done strobe, which comes one cycle after the flagged byte. In short mode the wrong value is never hidden by the finishing step. The checker adds faster symptoms on guard_o:
- A wrong seed is visible one cycle after a lone start, because guard_o must then read zero.
- A register that moves on an idle cycle changes guard_o one cycle later.

Comparisons against a bit-serial bench model over random lengths, gaps and mode toggles expose a wrong shift direction, tap, mode latch or continuation. The first completed stream that involves the fault shows it.

// File: rtl/guard_crc_pkg.sv
package guard_crc_pkg;
  typedef enum logic {
    GMODE_SHORT = 1'b0,
    GMODE_LONG  = 1'b1
  } gmode_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned LONG_W  = 64;

  localparam logic [SHORT_W-1:0] SHORT_POLY = 16'h8BB7;
  localparam logic [LONG_W-1:0]  LONG_POLY_REFL = 64'h9A6C_9329_AC4B_C9B5;
endpackage

// File: rtl/gcrc_step.sv
module gcrc_step #(
  parameter int unsigned W       = 16,
  parameter int unsigned BW      = 8,
  parameter logic [W-1:0] POLY   = '0,
  parameter bit          REFLECT = 1'b0
) (
  input  logic [W-1:0]  crc_i,
  input  logic [BW-1:0] byte_i,
  output logic [W-1:0]  crc_o
);
  localparam int unsigned TOP = W - 1;
  localparam int unsigned BOT = W - BW;

  generate
    if (REFLECT) begin : g_lsb_first
      always_comb begin
        logic [W-1:0] c;
        c = crc_i;
        c[BW-1:0] = c[BW-1:0] ^ byte_i;
        for (int k = 0; k < BW; k++) begin
          c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        crc_o = c;
      end
    end else begin : g_msb_first
      always_comb begin
        logic [W-1:0] c;
        c = crc_i;
        c[TOP:BOT] = c[TOP:BOT] ^ byte_i;
        for (int k = 0; k < BW; k++) begin
          c = c[TOP] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_o = c;
      end
    end
  endgenerate
endmodule

// File: rtl/gcrc_finish.sv
module gcrc_finish #(
  parameter int unsigned SW = 16,
  parameter int unsigned LW = 64
) (
  input  logic          long_i,
  input  logic [LW-1:0] crc_i,
  output logic [LW-1:0] guard_o
);
  always_comb begin
    if (long_i) guard_o = ~crc_i;
    else        guard_o = {{(LW-SW){1'b0}}, crc_i[SW-1:0]};
  end
endmodule

// File: rtl/guard_crc_engine.sv
module guard_crc_engine
  import guard_crc_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned SW = SHORT_W,
  parameter int unsigned LW = LONG_W,
  parameter logic [SW-1:0] SPOLY = SHORT_POLY,
  parameter logic [LW-1:0] LPOLY = LONG_POLY_REFL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [BW-1:0] data_i,
  input  logic          last_i,
  output logic          done_o,
  output logic [LW-1:0] guard_o
);
  localparam logic [LW-1:0] SEED_LONG  = '1;
  localparam logic [LW-1:0] SEED_SHORT = '0;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [LW-1:0] crc_q, crc_d, base;
  gmode_e        mode_q, mode_d;
  logic          done_q, done_d;
  logic          crc_en;
  logic [SW-1:0] step_s;
  logic [LW-1:0] step_l;

  // next state
  always_comb begin
    mode_d = start_i ? gmode_e'(mode_i) : mode_q;
    if (start_i) base = (gmode_e'(mode_i) == GMODE_LONG) ? SEED_LONG : SEED_SHORT;
    else         base = crc_q;
    if (valid_i) crc_d = (mode_d == GMODE_LONG) ? step_l : {{(LW-SW){1'b0}}, step_s};
    else         crc_d = base;
    crc_en = start_i | valid_i;
    done_d = valid_i & last_i;
  end

  gcrc_step #(.W(SW), .BW(BW), .POLY(SPOLY), .REFLECT(1'b0)) u_step_short (
    .crc_i (base[SW-1:0]),
    .byte_i(data_i),
    .crc_o (step_s)
  );

  gcrc_step #(.W(LW), .BW(BW), .POLY(LPOLY), .REFLECT(1'b1)) u_step_long (
    .crc_i (base),
    .byte_i(data_i),
    .crc_o (step_l)
  );

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      crc_q  <= '0;
      mode_q <= GMODE_SHORT;
      done_q <= 1'b0;
    end else begin
      if (crc_en) begin
        crc_q  <= crc_d;
        mode_q <= mode_d;
      end
      done_q <= done_d;
    end
  end

  gcrc_finish #(.SW(SW), .LW(LW)) u_finish (
    .long_i (mode_q == GMODE_LONG),
    .crc_i  (crc_q),
    .guard_o(guard_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/guard_crc_engine_chk.sv
module guard_crc_engine_chk #(
  parameter int unsigned LW = 64,
  parameter int unsigned SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          valid_i,
  input logic          last_i,
  input logic          long_q,
  input logic          done_o,
  input logic [LW-1:0] guard_o
);
  // R5
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && last_i) |=> done_o);
  // R5
  a_r5_done_only_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && last_i) |=> !done_o);
  // R4
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !start_i) |=> $stable(guard_o));
  // R6
  a_r6_seed_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_i) |=> (guard_o == '0));
  // R7
  a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(long_q));
  // R2
  a_r2_short_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !long_q) |-> (guard_o[LW-1:SW] == '0));
endmodule

bind guard_crc_engine guard_crc_engine_chk #(.LW(LW), .SW(SW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start_i(start_i),
  .valid_i(valid_i),
  .last_i (last_i),
  .long_q (mode_q == guard_crc_pkg::GMODE_LONG),
  .done_o (done_o),
  .guard_o(guard_o)
);

// File: tb/guard_crc_engine_test.sv
module guard_crc_engine_test;
  logic        clk, rst_n;
  logic        mode_i, start_i, valid_i, last_i;
  logic [7:0]  data_i;
  logic        done_o;
  logic [63:0] guard_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  logic [7:0] mem [0:1023];

  guard_crc_engine uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_i(start_i),
    .valid_i(valid_i), .data_i(data_i), .last_i(last_i),
    .done_o(done_o), .guard_o(guard_o)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // bit-serial reference models
  function automatic logic [63:0] ref16(logic [15:0] c0, int first, int n);
    logic [15:0] c = c0;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ mem[first+i][b];
        c = c << 1;
        if (fb) c = c ^ 16'h8BB7;
      end
    return {48'd0, c};
  endfunction

  function automatic logic [63:0] ref64(logic [63:0] c0, int first, int n);
    logic [63:0] c = c0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ mem[first+i][b];
        c = c >> 1;
        if (fb) c = c ^ 64'h9A6C_9329_AC4B_C9B5;
      end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stream bytes; caller is at a negedge; returns at the negedge after the last byte
  task automatic feed(input int first, input int n, input bit md, input bit do_start,
                      input bit do_last, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        valid_i = 0; start_i = 0; last_i = 0; mode_i = $urandom % 2;
        @(negedge clk);
      end
      valid_i = 1;
      data_i  = mem[first+i];
      start_i = do_start && (i == 0);
      mode_i  = start_i ? md : 1'($urandom % 2);   // R7: toggles off start
      last_i  = do_last && (i == n - 1);
      @(negedge clk);
    end
    valid_i = 0; start_i = 0; last_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      mode_i = $urandom % 2;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [63:0] exp, c;
    int dummy;
    dummy = $urandom(32'h5EED_0042);
    rst_n = 0; mode_i = 0; start_i = 0; valid_i = 0; last_i = 0; data_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(done_o == 1'b0, "R1 done", {63'd0, done_o}, 64'd0);
    check(guard_o == 64'd0, "R1 guard", guard_o, 64'd0);

    // R2 / R3 check strings
    for (int i = 0; i < 9; i++) mem[i] = 8'h31 + 8'(i);
    feed(0, 9, 1'b0, 1'b1, 1'b1, 1'b0);
    check(done_o == 1'b1, "R5 done short", {63'd0, done_o}, 64'd1);
    check(guard_o == 64'hD0DB, "R2 check string", guard_o, 64'hD0DB);
    @(negedge clk);
    check(done_o == 1'b0, "R5 single pulse", {63'd0, done_o}, 64'd0);
    feed(0, 9, 1'b1, 1'b1, 1'b1, 1'b1);
    check(guard_o == 64'hAE8B_1486_0A79_9888, "R3 check string", guard_o, 64'hAE8B_1486_0A79_9888);

    // R4 idle holds
    exp = guard_o;
    idle(5);
    check(guard_o == exp, "R4 idle hold", guard_o, exp);

    // R9 zero block
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    feed(0, 512, 1'b0, 1'b1, 1'b1, 1'b0);
    check(guard_o == 64'd0, "R9 short zero", guard_o, 64'd0);
    feed(0, 512, 1'b1, 1'b1, 1'b1, 1'b0);
    exp = ~ref64('1, 0, 512);
    check(guard_o == exp && guard_o != 64'd0, "R9 long zero", guard_o, exp);

    // R6 lone start then bytes without start
    for (int i = 0; i < 32; i++) mem[i] = 8'($urandom);
    for (int m = 0; m < 2; m++) begin
      feed(0, 5, 1'(m ^ 1), 1'b1, 1'b0, 1'b0);    // leftover state, other mode
      start_i = 1; valid_i = 0; mode_i = 1'(m);
      @(negedge clk);
      start_i = 0; mode_i = 1'(m ^ 1);
      @(negedge clk);
      check(guard_o == 64'd0, "R6 seed reads zero", guard_o, 64'd0);
      feed(0, 20, 1'(m), 1'b0, 1'b1, 1'b1);
      exp = (m == 1) ? ~ref64('1, 0, 20) : ref16(16'd0, 0, 20);
      check(guard_o == exp, "R6 reseed", guard_o, exp);
    end

    // random streams, R2 R3 R4 R5 R7
    for (int t = 0; t < 60; t++) begin
      int n = 1 + ($urandom % 64);
      bit md = $urandom % 2;
      for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
      if (t % 3 == 0) begin
        for (int i = 0; i < n; i++) mem[i] = (i % 2) ? 8'hFF : 8'h00;
      end
      feed(0, n, md, 1'b1, 1'b1, 1'b1);
      exp = md ? ~ref64('1, 0, n) : ref16(16'd0, 0, n);
      check(done_o == 1'b1, "R5 done random", {63'd0, done_o}, 64'd1);
      check(guard_o == exp, md ? "R3 random" : "R2 random", guard_o, exp);
    end

    // R8 chained data then metadata
    for (int t = 0; t < 12; t++) begin
      int nd = 1 + ($urandom % 512);
      int nm = 1 + ($urandom % 56);
      bit md = t % 2;
      for (int i = 0; i < nd + nm; i++) mem[i] = 8'($urandom);
      feed(0, nd, md, 1'b1, 1'b1, 1'b1);
      c = md ? ref64('1, 0, nd) : ref16(16'd0, 0, nd);
      exp = md ? ~c : c;
      check(guard_o == exp, "R8 first segment", guard_o, exp);
      idle(1 + $urandom % 4);
      feed(nd, nm, md, 1'b0, 1'b1, 1'b1);
      exp = md ? ~ref64(c, nd, nm) : ref16(c[15:0], nd, nm);
      check(guard_o == exp, "R8 chained", guard_o, exp);
    end

    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule